// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a shared multiplexed bus made of a 32-bit address/data field and a 4-bit active-low command/byte-enable field with one even-parity bit. When this agent drives the bus, the block computes the parity of the values it drives. It places that bit on its parity output, with an output enable, one clock later. When this agent receives the bus, the block compares the parity bit that arrives one clock after the values against its own computation. It then reports mismatches on a fixed pipeline.

A mismatch on a data transfer goes to a shared data-error line. That line is driven low for at least one clock, then driven high for exactly one clock, and then released. A mismatch on an address phase goes to an open-drain system-error line, which the block only ever pulls low. Two enable inputs gate this reporting. Two sticky status bits record that an error was detected and that a system error was signalled. Bus protocol sequencing stays outside the block. The surrounding agent supplies phase qualifiers that say which cycles are address phases, which are completed data transfers and whether this agent is the driver.

Top module: `bus_parity_unit`

## Requirements
- R1: While reset is active, both output enables are 0, the data-error line reads 1 (released), the system-error pull-down is 0 and both status bits are 0.
- R2: In the cycle after a bus cycle, `parity_o` equals the XOR of all 32 data bits and all 4 command/byte-enable bits of that cycle, and `parity_oe_o` equals the `drive_i` value of that cycle.
- R3: Every one of the 36 protected bits takes part in the parity: flipping any single bit flips `parity_o`.
- R4: When a received transfer (`xfer_i`=1, `drive_i`=0) in cycle N is followed in cycle N+1 by a `parity_i` that makes the total count of ones odd, and `derr_resp_en_i`=1 in cycle N+1, the data-error line is driven low in cycle N+2. It is driven high for one clock after the last low cycle, then released. Received transfers with correct parity produce no report.
- R5: Data errors in consecutive or near-consecutive transfers keep the data-error line low without a gap. A new error during the drive-high cycle restarts the low drive.
- R6: With `derr_resp_en_i`=0, a data parity error never drives the data-error line, but it still sets the detected status bit.
- R7: After an address phase whose command field is 4'b0001 (broadcast cycle), data parity errors in that transaction set the detected bit but do not drive the data-error line. A later address phase with another command restores normal reporting.
- R8: An address-phase parity error (`addr_phase_i`=1, `drive_i`=0) with `sys_err_en_i`=1 pulls `sys_err_pd_o` high for one clock in cycle N+2 and sets both status bits. It never drives the data-error line. The system-error line has no drive-high path.
- R9: With `sys_err_en_i`=0, an address parity error leaves `sys_err_pd_o` at 0 and the signalled bit clear, while the detected bit is set.
- R10: Cycles in which this agent drives the bus (`drive_i`=1) are never checked, whatever arrives on `parity_i`.
- R11: Both status bits are sticky. `stat_clr_i[0]`=1 clears the detected bit and `stat_clr_i[1]`=1 clears the signalled bit. A new error in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_data_i | input | 32 | Address/data field as seen on the bus |
| bus_cmd_be_n_i | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| parity_i | input | 1 | Parity bit sampled from the bus, one clock late |
| addr_phase_i | input | 1 | Current cycle is an address phase |
| xfer_i | input | 1 | Current cycle completes a data transfer |
| drive_i | input | 1 | This agent drives the data and command fields this cycle |
| derr_resp_en_i | input | 1 | Enable for data-error reporting |
| sys_err_en_i | input | 1 | Enable for system-error reporting |
| stat_clr_i | input | 2 | Write-one-to-clear strobe: bit 0 detected, bit 1 signalled |
| parity_o | output | 1 | Generated parity, one clock after the protected values |
| parity_oe_o | output | 1 | Output enable for `parity_o` |
| data_err_n_o | output | 1 | Data-error line value, active low |
| data_err_oe_o | output | 1 | Output enable for the data-error line |
| sys_err_pd_o | output | 1 | 1 pulls the open-drain system-error line low |
| det_parity_err_o | output | 1 | Sticky: a parity error was detected |
| sig_sys_err_o | output | 1 | Sticky: a system error was signalled |

## Verification
The bench aims at the release sequence of the data-error line. A design that released straight from low would leave the line floating low. A design that ignored errors arriving in the drive-high cycle would open a gap in back-to-back reports. It walks a single one across all 36 protected bits, which catches a design that leaves out a bit or byte-gates the parity. It also covers the broadcast-command exemption and the two enables, where a wrong gate either reports an error it should suppress or loses the detected bit. Finally it clears a status bit in the same cycle as a new error, which exposes a design where the clear wins over the set. It also feeds wrong parity while the agent drives, which flags a design that checks its own cycles.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  // Report state of the shared data-error line
  typedef enum logic [1:0] {
    DERR_IDLE = 2'd0,  // released
    DERR_LOW  = 2'd1,  // driven low
    DERR_HIGH = 2'd2   // driven high for one clock before release
  } derr_state_e;

  // Broadcast command code on the command/byte-enable lines
  localparam logic [3:0] CMD_BROADCAST = 4'b0001;

  // Status strobe bit positions
  localparam int unsigned STAT_DET = 0;
  localparam int unsigned STAT_SIG = 1;
  localparam int unsigned STAT_W   = 2;

endpackage

// File: rtl/bpu_rst_sync.sv
module bpu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/bpu_par_gen.sv
module bpu_par_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CMD_W-1:0]  cmd_be_n_i,
  input  logic              drive_i,
  output logic              parity_o,
  output logic              parity_oe_o
);

  localparam int unsigned PROT_W = DATA_W + CMD_W;

  logic [PROT_W-1:0] prot_vec;
  logic              par_d, par_q;
  logic              oe_d, oe_q;

  always_comb begin
    prot_vec = {data_i, cmd_be_n_i};
    par_d    = ^prot_vec;
    oe_d     = drive_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign parity_o    = par_q;
  assign parity_oe_o = oe_q;

  // R2: the enable only rises after a cycle in which the agent drove
  a_r2_oe_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_oe_o) |-> $past(drive_i));

endmodule

// File: rtl/bpu_par_chk.sv
module bpu_par_chk
  import bpu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CMD_W-1:0]  cmd_be_n_i,
  input  logic              parity_i,
  input  logic              addr_phase_i,
  input  logic              xfer_i,
  input  logic              drive_i,
  output logic              addr_err_o,
  output logic              data_err_o,
  output logic              broadcast_o
);

  localparam int unsigned PROT_W = DATA_W + CMD_W;
  localparam logic [CMD_W-1:0] BCAST = CMD_W'(CMD_BROADCAST);

  logic [PROT_W-1:0] prot_vec;
  logic              exp_d, exp_q;
  logic              achk_d, achk_q;
  logic              dchk_d, dchk_q;
  logic              bc_d, bc_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              cmd_en;
  logic              mism;

  always_comb begin
    prot_vec = {data_i, cmd_be_n_i};
    exp_d    = ^prot_vec;
    achk_d   = addr_phase_i & ~drive_i;
    dchk_d   = xfer_i & ~drive_i;
    bc_d     = dchk_d & (cmd_q == BCAST);
    cmd_en   = addr_phase_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= 1'b0;
      achk_q <= 1'b0;
      dchk_q <= 1'b0;
      bc_q   <= 1'b0;
    end else begin
      exp_q  <= exp_d;
      achk_q <= achk_d;
      dchk_q <= dchk_d;
      bc_q   <= bc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_be_n_i;
  end

  always_comb begin
    mism        = exp_q ^ parity_i;
    addr_err_o  = achk_q & mism;
    data_err_o  = dchk_q & mism;
    broadcast_o = bc_q;
  end

  // R10: a cycle driven by this agent never produces an error one clock later
  a_r10_no_check_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drive_i) |-> !(addr_err_o || data_err_o));

endmodule

// File: rtl/bpu_derr_drv.sv
module bpu_derr_drv
  import bpu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic err_n_o,
  output logic err_oe_o
);

  derr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (fire_i) begin
      state_d = DERR_LOW;
    end else begin
      case (state_q)
        DERR_LOW:  state_d = DERR_HIGH;
        DERR_HIGH: state_d = DERR_IDLE;
        default:   state_d = DERR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DERR_IDLE;
    else        state_q <= state_d;
  end

  assign err_oe_o = (state_q != DERR_IDLE);
  assign err_n_o  = (state_q != DERR_LOW);

  // R4: release only follows a cycle driven high
  a_r4_high_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_oe_o) |-> $past(err_n_o));

  // R4: a report request drives the line low in the next cycle
  a_r4_fire_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (err_oe_o && !err_n_o));

  // R4: after a low cycle with no new request the line is driven high
  a_r4_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (err_oe_o && !err_n_o && !fire_i) |=> (err_oe_o && err_n_o));

endmodule

// File: rtl/bpu_status.sv
module bpu_status
  import bpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_set_i,
  input  logic              sig_set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic              det_o,
  output logic              sig_o
);

  logic det_d, det_q;
  logic sig_d, sig_q;

  always_comb begin
    det_d = det_set_i | (det_q & ~clr_i[STAT_DET]);
    sig_d = sig_set_i | (sig_q & ~clr_i[STAT_SIG]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      sig_q <= 1'b0;
    end else begin
      det_q <= det_d;
      sig_q <= sig_d;
    end
  end

  assign det_o = det_q;
  assign sig_o = sig_q;

  // R11: a set bit stays set unless its clear strobe is given
  a_r11_det_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (det_o && !clr_i[STAT_DET]) |=> det_o);

  // R11: a set request wins over a simultaneous clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    det_set_i |=> det_o);

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bpu_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CMD_W     = 4,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [CMD_W-1:0]  bus_cmd_be_n_i,
  input  logic              parity_i,
  input  logic              addr_phase_i,
  input  logic              xfer_i,
  input  logic              drive_i,
  input  logic              derr_resp_en_i,
  input  logic              sys_err_en_i,
  input  logic [STAT_W-1:0] stat_clr_i,
  output logic              parity_o,
  output logic              parity_oe_o,
  output logic              data_err_n_o,
  output logic              data_err_oe_o,
  output logic              sys_err_pd_o,
  output logic              det_parity_err_o,
  output logic              sig_sys_err_o
);

  logic rst_i_n;
  logic addr_err, data_err, bcast;
  logic derr_fire, serr_fire, any_err;
  logic pd_q;

  bpu_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bpu_par_gen #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_gen (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .data_i      (bus_data_i),
    .cmd_be_n_i  (bus_cmd_be_n_i),
    .drive_i     (drive_i),
    .parity_o    (parity_o),
    .parity_oe_o (parity_oe_o)
  );

  bpu_par_chk #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .data_i       (bus_data_i),
    .cmd_be_n_i   (bus_cmd_be_n_i),
    .parity_i     (parity_i),
    .addr_phase_i (addr_phase_i),
    .xfer_i       (xfer_i),
    .drive_i      (drive_i),
    .addr_err_o   (addr_err),
    .data_err_o   (data_err),
    .broadcast_o  (bcast)
  );

  always_comb begin
    derr_fire = data_err & ~bcast & derr_resp_en_i;
    serr_fire = addr_err & sys_err_en_i;
    any_err   = addr_err | data_err;
  end

  bpu_derr_drv u_derr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .fire_i   (derr_fire),
    .err_n_o  (data_err_n_o),
    .err_oe_o (data_err_oe_o)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pd_q <= 1'b0;
    else          pd_q <= serr_fire;
  end

  assign sys_err_pd_o = pd_q;

  bpu_status u_stat (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .det_set_i (any_err),
    .sig_set_i (serr_fire),
    .clr_i     (stat_clr_i),
    .det_o     (det_parity_err_o),
    .sig_o     (sig_sys_err_o)
  );

  // R8: a system-error pull-down is always accompanied by the signalled bit
  a_r8_pd_sets_sig: assert property (@(posedge clk) disable iff (!rst_i_n)
    sys_err_pd_o |-> sig_sys_err_o);

  // R7: a data error inside a broadcast transaction never starts a low drive
  a_r7_broadcast_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (data_err && bcast) |=> !(data_err_oe_o && !data_err_n_o));

  // R6: with reporting disabled, a data error does not start a low drive
  a_r6_resp_off_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (data_err && !derr_resp_en_i && !(data_err_oe_o && !data_err_n_o))
      |=> !(data_err_oe_o && !data_err_n_o));

endmodule

// File: tb/test_bus_parity_unit.sv
module test_bus_parity_unit;

  typedef struct packed {
    logic [31:0] data;
    logic [3:0]  cmd;
    logic        par;
    logic        addr;
    logic        xfer;
    logic        drv;
    logic        pe;
    logic        se;
    logic [1:0]  clr;
    logic [31:0] req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_data;
  logic [3:0]  bus_cmd;
  logic        par_in, addr_ph, xfer, drive, pe_en, se_en;
  logic [1:0]  clr;
  logic        par_out, par_oe, derr_n, derr_oe, serr_pd, det, sig;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;

  item_t       sb_q[$];
  item_t       prev_it;
  logic        next_par;
  logic        g_pe, g_se;
  logic [31:0] cur_req;

  // model state
  int unsigned m_state;
  logic        m_det, m_sig;
  logic [3:0]  m_cmd;

  always #10 clk = ~clk;

  bus_parity_unit i_bus_parity_unit (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_data_i       (bus_data),
    .bus_cmd_be_n_i   (bus_cmd),
    .parity_i         (par_in),
    .addr_phase_i     (addr_ph),
    .xfer_i           (xfer),
    .drive_i          (drive),
    .derr_resp_en_i   (pe_en),
    .sys_err_en_i     (se_en),
    .stat_clr_i       (clr),
    .parity_o         (par_out),
    .parity_oe_o      (par_oe),
    .data_err_n_o     (derr_n),
    .data_err_oe_o    (derr_oe),
    .sys_err_pd_o     (serr_pd),
    .det_parity_err_o (det),
    .sig_sys_err_o    (sig)
  );

  task automatic cmp(input string what, input logic act, input logic exp, input logic [31:0] req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Monitor side of the scoreboard: pair (previous item, just-sampled item)
  task automatic score(input item_t p, input item_t c);
    logic e_par, mism, a_err, d_err, bc, d_fire, s_fire;
    e_par  = ^{c.data, c.cmd};
    mism   = (^{p.data, p.cmd}) != c.par;
    a_err  = p.addr && !p.drv && mism;
    d_err  = p.xfer && !p.drv && mism;
    bc     = (m_cmd == 4'b0001);
    if (p.addr) m_cmd = p.cmd;
    d_fire = d_err && !bc && c.pe;
    s_fire = a_err && c.se;
    if (d_fire)            m_state = 1;
    else if (m_state == 1) m_state = 2;
    else                   m_state = 0;
    m_det = (a_err || d_err) || (m_det && !c.clr[0]);
    m_sig = s_fire || (m_sig && !c.clr[1]);
    cmp("parity", par_out, e_par, c.req);
    cmp("parity_oe", par_oe, c.drv, c.req);
    cmp("derr_oe", derr_oe, m_state != 0, c.req);
    cmp("derr_n", derr_n, m_state != 1, c.req);
    cmp("sys_err_pd", serr_pd, s_fire, c.req);
    cmp("det", det, m_det, c.req);
    cmp("sig", sig, m_sig, c.req);
  endtask

  // Driver side: check what the last edge produced, then drive a new cycle
  task automatic step(input logic [31:0] d, input logic [3:0] c, input logic a,
                      input logic x, input logic dr, input logic flip, input logic [1:0] cl);
    item_t it;
    @(negedge clk);
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      score(prev_it, it);
      prev_it = it;
    end
    bus_data = d; bus_cmd = c; addr_ph = a; xfer = x; drive = dr; clr = cl;
    pe_en = g_pe; se_en = g_se; par_in = next_par;
    next_par = (^{d, c}) ^ flip;
    it = '{data: d, cmd: c, par: par_in, addr: a, xfer: x, drv: dr,
           pe: g_pe, se: g_se, clr: cl, req: cur_req};
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 0, 0, 0, 0, 2'b00);
  endtask

  task automatic clear_all();
    step('0, '0, 0, 0, 0, 0, 2'b11);
    idle(1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_data = '0; bus_cmd = '0; par_in = 1'b0; addr_ph = 1'b0;
    xfer = 1'b0; drive = 1'b0; pe_en = 1'b1; se_en = 1'b1; clr = '0;
    g_pe = 1'b1; g_se = 1'b1; next_par = 1'b0; prev_it = '0;
    m_state = 0; m_det = 1'b0; m_sig = 1'b0; m_cmd = '0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    cmp("parity_oe", par_oe, 1'b0, "R1");
    cmp("derr_oe", derr_oe, 1'b0, "R1");
    cmp("derr_n", derr_n, 1'b1, "R1");
    cmp("sys_err_pd", serr_pd, 1'b0, "R1");
    cmp("det", det, 1'b0, "R1");
    cmp("sig", sig, 1'b0, "R1");
    rst_n = 1'b1;
    idle(4);

    cur_req = "R2";
    step(32'hDEAD_BEEF, 4'h7, 1, 0, 1, 0, 2'b00);
    step(32'h0000_0000, 4'h0, 0, 1, 1, 0, 2'b00);
    step(32'hFFFF_FFFF, 4'hF, 0, 1, 1, 0, 2'b00);
    step(32'h1234_5678, 4'hA, 0, 1, 0, 0, 2'b00);
    step(32'h8000_0001, 4'h1, 0, 1, 1, 0, 2'b00);
    idle(2);

    cur_req = "R3";
    for (int i = 0; i < 32; i++) step(32'd1 << i, 4'h0, 0, 1, 1, 0, 2'b00);
    for (int i = 0; i < 4; i++)  step('0, 4'd1 << i, 0, 1, 1, 0, 2'b00);
    idle(2);

    cur_req = "R10";
    step(32'hA5A5_0F0F, 4'h3, 1, 0, 1, 1, 2'b00);
    step(32'h5A5A_F0F0, 4'h0, 0, 1, 1, 1, 2'b00);
    idle(4);

    cur_req = "R4";
    step(32'h0BAD_F00D, 4'h6, 1, 0, 0, 0, 2'b00);
    step(32'h1111_2222, 4'h0, 0, 1, 0, 0, 2'b00);
    step(32'h3333_4444, 4'h0, 0, 1, 0, 1, 2'b00);
    idle(5);
    clear_all();

    cur_req = "R5";
    step(32'h0000_00FF, 4'h0, 0, 1, 0, 1, 2'b00);
    step(32'h0000_FF00, 4'h0, 0, 1, 0, 1, 2'b00);
    step(32'h00FF_0000, 4'h0, 0, 1, 0, 0, 2'b00);
    step(32'hFF00_0000, 4'h0, 0, 1, 0, 1, 2'b00);
    idle(5);
    clear_all();

    cur_req = "R11";
    step(32'hCAFE_0001, 4'h0, 0, 1, 0, 1, 2'b00);
    step('0, '0, 0, 0, 0, 0, 2'b01);
    idle(4);
    step('0, '0, 0, 0, 0, 0, 2'b01);
    idle(2);

    cur_req = "R6";
    g_pe = 1'b0;
    step(32'h7777_0000, 4'h2, 0, 1, 0, 1, 2'b00);
    idle(4);
    g_pe = 1'b1;
    clear_all();

    cur_req = "R7";
    step(32'h0000_0000, 4'b0001, 1, 0, 0, 0, 2'b00);
    step(32'h1357_9BDF, 4'h0, 0, 1, 0, 1, 2'b00);
    idle(4);
    step(32'h2000_0000, 4'b0111, 1, 0, 0, 0, 2'b00);
    step(32'h2468_ACE0, 4'h0, 0, 1, 0, 1, 2'b00);
    idle(5);
    clear_all();

    cur_req = "R8";
    step(32'h4000_0010, 4'b0110, 1, 0, 0, 1, 2'b00);
    idle(4);
    clear_all();

    cur_req = "R9";
    g_se = 1'b0;
    step(32'h4000_0020, 4'b0110, 1, 0, 0, 1, 2'b00);
    idle(4);
    g_se = 1'b1;
    clear_all();

    idle(3);
    finish_run();
  end

endmodule